// File: doc/BRIEF.md
# Four-Way Write-Back Data Cache

This block is a data cache for a processor with 32-bit byte addresses. It holds 16 KB in 256 sets of four ways. Each line is four 32-bit words. The processor side takes one request at a time through a valid/ready handshake. A request is either a word read or a full-word write. The result comes back as a one-cycle response pulse, and a read carries its data with that pulse.

A lookup reads the four ways of the addressed set and compares their tags at the same time. A hit is served from the cache. A write hit changes only the cached word and marks the way dirty. On a miss, the controller takes a victim way from an external replacement-policy block. If that victim is valid and dirty, its whole line is copied back to memory first. The missing line is then refilled, and the access completes in a final step. The memory side moves whole 128-bit lines through a request/acknowledge port. The controller reports every hit and every fill back to the replacement block.

Top module: `wb_cache`

## Requirements
- R1: A request accepted while `cpu_ready` is high that hits completes with a single-cycle `cpu_resp` on the second rising edge after acceptance. For a read, `cpu_rdata` holds the requested word in that same cycle.
- R2: A synchronous reset clears every valid and dirty bit. It also leaves `cpu_ready` high and both `cpu_resp` and `mem_req` low, so the first access to any line misses.
- R3: The address fields are tag = bits 31:12, set = bits 11:4, word = bits 3:2 and byte = bits 1:0. An access hits only when a valid way of its set holds its tag, and at most one way can match. A miss performs exactly one line refill from address {tag, set, 4'b0000}.
- R4: A read returns the word chosen by the word field. Word k of a line travels in bits 32k+31 down to 32k of a memory line.
- R5: A write hit changes only the addressed cached word and marks the way dirty. It causes no memory transaction.
- R6: On a miss whose victim way is valid and dirty, the victim's current line is written to {victim tag, set, 4'b0000} before the refill begins.
- R7: On a miss whose victim is invalid or clean, there is no write-back. A line installed by a read miss is clean and can later be evicted without a write-back.
- R8: A write miss refills the line, then writes the word into it and marks the way dirty.
- R9: While a miss is serviced, `cpu_ready` stays low. `mem_req` is held with a stable `mem_addr` and `mem_we` until `mem_ack` arrives.
- R10: `repl_touch` pulses once on a hit, with the hit way, and once on a refill, with the victim way. `repl_set` shows the set. The victim is taken from `repl_victim` in the lookup cycle.
- R11: The byte-offset bits are ignored, for both reads and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_valid | input | 1 | Processor request present |
| cpu_ready | output | 1 | Cache can accept a request |
| cpu_we | input | 1 | 1 = word write, 0 = read |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write word |
| cpu_resp | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Read word, valid with `cpu_resp` |
| mem_req | output | 1 | Line transfer request |
| mem_we | output | 1 | 1 = write-back, 0 = refill |
| mem_addr | output | 32 | Line-aligned byte address |
| mem_wline | output | 128 | Line written back |
| mem_rline | input | 128 | Refill line, valid with `mem_ack` |
| mem_ack | input | 1 | Transfer complete |
| repl_set | output | 8 | Set of the current access |
| repl_victim | input | 2 | Way to evict on a miss |
| repl_touch | output | 1 | Hit or fill notification |
| repl_way | output | 2 | Way that was hit or filled |

## Verification
Two events can land on the same set in close succession. In the first, a write hit leaves a way dirty, and a later miss then picks that same way as its victim. Here the write-back must carry the newly written word and must come before the refill. In the second, a read-miss refill and the eviction decision for that way meet, and a freshly filled line has to count as clean. The bench provokes both cases. It chooses `repl_victim` itself and forces repeated conflicts: six tags compete for four ways in a few sets, including the first and last set. It judges each access against a model that tracks tags, valid bits and dirty bits, and against a shadow copy of every written word. Each observed write-back line must equal the shadow line.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_LOOKUP,
    S_WRBACK,
    S_REFILL,
    S_FINISH
  } wbc_state_e;
endpackage

// File: rtl/wbc_tag_match.sv
module wbc_tag_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 20,
  parameter int WAY_W = 2
) (
  input  logic [WAYS-1:0]            way_valid,
  input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
  input  logic [TAG_W-1:0]           req_tag,
  output logic [WAYS-1:0]            hit_vec,
  output logic                       hit,
  output logic [WAY_W-1:0]           hit_way
);
  // one comparator per way, all in parallel
  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign hit_vec[g] = way_valid[g] && (way_tag[g] == req_tag);
  end

  assign hit = |hit_vec;

  always_comb begin
    hit_way = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (hit_vec[i]) hit_way = WAY_W'(i);
    end
  end
endmodule

// File: rtl/wbc_arrays.sv
module wbc_arrays #(
  parameter int SET_W  = 8,
  parameter int WAYS   = 4,
  parameter int WAY_W  = 2,
  parameter int TAG_W  = 20,
  parameter int WORD_W = 32,
  parameter int OFF_W  = 2,
  parameter int LINE_W = 128
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [SET_W-1:0]            set_i,
  output logic [WAYS-1:0]             rd_valid,
  output logic [WAYS-1:0]             rd_dirty,
  output logic [WAYS-1:0][TAG_W-1:0]  rd_tag,
  output logic [WAYS-1:0][LINE_W-1:0] rd_line,
  input  logic                        fill_en,
  input  logic [WAY_W-1:0]            fill_way,
  input  logic [TAG_W-1:0]            fill_tag,
  input  logic [LINE_W-1:0]           fill_line,
  input  logic                        wr_en,
  input  logic [WAY_W-1:0]            wr_way,
  input  logic [OFF_W-1:0]            wr_word,
  input  logic [WORD_W-1:0]           wr_data
);
  localparam int SETS = 1 << SET_W;

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    logic [SETS-1:0]   valid_q;
    logic [SETS-1:0]   dirty_q;
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [LINE_W-1:0] data_q [SETS];
    logic fill_me, wr_me;

    assign fill_me = fill_en && (fill_way == WAY_W'(g));
    assign wr_me   = wr_en && (wr_way == WAY_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        valid_q <= '0;
        dirty_q <= '0;
      end else if (fill_me) begin
        valid_q[set_i] <= 1'b1;
        dirty_q[set_i] <= 1'b0;
      end else if (wr_me) begin
        dirty_q[set_i] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (fill_me) begin
        tag_q[set_i]  <= fill_tag;
        data_q[set_i] <= fill_line;
      end else if (wr_me) begin
        data_q[set_i][wr_word*WORD_W +: WORD_W] <= wr_data;
      end
    end

    assign rd_valid[g] = valid_q[set_i];
    assign rd_dirty[g] = dirty_q[set_i];
    assign rd_tag[g]   = tag_q[set_i];
    assign rd_line[g]  = data_q[set_i];
  end
endmodule

// File: rtl/wbc_ctrl.sv
module wbc_ctrl
  import wbc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SET_W  = 8,
  parameter int WAYS   = 4,
  parameter int WAY_W  = 2,
  parameter int TAG_W  = 20,
  parameter int WORD_W = 32,
  parameter int OFF_W  = 2,
  parameter int BYTE_W = 2,
  parameter int LINE_W = 128
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cpu_valid,
  output logic                        cpu_ready,
  input  logic                        cpu_we,
  input  logic [ADDR_W-1:0]           cpu_addr,
  input  logic [WORD_W-1:0]           cpu_wdata,
  output logic                        cpu_resp,
  output logic [WORD_W-1:0]           cpu_rdata,
  output logic [SET_W-1:0]            set_o,
  output logic [TAG_W-1:0]            tag_o,
  input  logic                        hit,
  input  logic [WAY_W-1:0]            hit_way,
  input  logic [WAYS-1:0]             rd_valid,
  input  logic [WAYS-1:0]             rd_dirty,
  input  logic [WAYS-1:0][TAG_W-1:0]  rd_tag,
  input  logic [WAYS-1:0][LINE_W-1:0] rd_line,
  output logic                        fill_en,
  output logic [WAY_W-1:0]            fill_way,
  output logic [TAG_W-1:0]            fill_tag,
  output logic [LINE_W-1:0]           fill_line,
  output logic                        wr_en,
  output logic [WAY_W-1:0]            wr_way,
  output logic [OFF_W-1:0]            wr_word,
  output logic [WORD_W-1:0]           wr_data,
  output logic                        mem_req,
  output logic                        mem_we,
  output logic [ADDR_W-1:0]           mem_addr,
  output logic [LINE_W-1:0]           mem_wline,
  input  logic [LINE_W-1:0]           mem_rline,
  input  logic                        mem_ack,
  output logic [SET_W-1:0]            repl_set,
  input  logic [WAY_W-1:0]            repl_victim,
  output logic                        repl_touch,
  output logic [WAY_W-1:0]            repl_way,
  output logic                        ev_hit,
  output logic                        ev_miss_dirty,
  output logic                        ev_miss_clean,
  output logic                        ev_fill
);
  // address field arithmetic
  function automatic logic [TAG_W-1:0] f_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction
  function automatic logic [SET_W-1:0] f_set(input logic [ADDR_W-1:0] a);
    return a[BYTE_W+OFF_W +: SET_W];
  endfunction
  function automatic logic [OFF_W-1:0] f_word(input logic [ADDR_W-1:0] a);
    return a[BYTE_W +: OFF_W];
  endfunction
  function automatic logic [ADDR_W-1:0] f_line_addr(input logic [TAG_W-1:0] t,
                                                    input logic [SET_W-1:0] s);
    return {t, s, {(OFF_W+BYTE_W){1'b0}}};
  endfunction
  function automatic logic [WORD_W-1:0] f_pick(input logic [LINE_W-1:0] line,
                                               input logic [OFF_W-1:0] w);
    return line[w*WORD_W +: WORD_W];
  endfunction

  wbc_state_e         state_q;
  logic [ADDR_W-1:0]  req_addr_q;
  logic               req_we_q;
  logic [WORD_W-1:0]  req_wd_q;
  logic [WAY_W-1:0]   vic_q;
  logic               resp_q;
  logic [WORD_W-1:0]  rdata_q;
  logic               victim_dirty;
  logic               in_lookup, in_finish;
  logic               unused_byte;

  assign unused_byte  = ^req_addr_q[BYTE_W-1:0];
  assign set_o        = f_set(req_addr_q);
  assign tag_o        = f_tag(req_addr_q);
  assign in_lookup    = (state_q == S_LOOKUP);
  assign in_finish    = (state_q == S_FINISH);
  assign victim_dirty = rd_valid[repl_victim] && rd_dirty[repl_victim];

  assign ev_hit        = in_lookup && hit;
  assign ev_miss_dirty = in_lookup && !hit && victim_dirty;
  assign ev_miss_clean = in_lookup && !hit && !victim_dirty;
  assign ev_fill       = (state_q == S_REFILL) && mem_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= S_IDLE;
      req_addr_q <= '0;
      req_we_q   <= 1'b0;
      req_wd_q   <= '0;
      vic_q      <= '0;
      resp_q     <= 1'b0;
      rdata_q    <= '0;
    end else begin
      resp_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (cpu_valid) begin
          req_addr_q <= cpu_addr;
          req_we_q   <= cpu_we;
          req_wd_q   <= cpu_wdata;
          state_q    <= S_LOOKUP;
        end
        S_LOOKUP: if (hit) begin
          if (!req_we_q) rdata_q <= f_pick(rd_line[hit_way], f_word(req_addr_q));
          resp_q  <= 1'b1;
          state_q <= S_IDLE;
        end else begin
          vic_q   <= repl_victim;
          state_q <= victim_dirty ? S_WRBACK : S_REFILL;
        end
        S_WRBACK: if (mem_ack) state_q <= S_REFILL;
        S_REFILL: if (mem_ack) state_q <= S_FINISH;
        S_FINISH: begin
          if (!req_we_q) rdata_q <= f_pick(rd_line[vic_q], f_word(req_addr_q));
          resp_q  <= 1'b1;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign cpu_ready = (state_q == S_IDLE);
  assign cpu_resp  = resp_q;
  assign cpu_rdata = rdata_q;

  // memory side: write-back of the victim, then refill of the request line
  assign mem_req   = (state_q == S_WRBACK) || (state_q == S_REFILL);
  assign mem_we    = (state_q == S_WRBACK);
  assign mem_addr  = mem_we ? f_line_addr(rd_tag[vic_q], set_o)
                            : f_line_addr(tag_o, set_o);
  assign mem_wline = rd_line[vic_q];

  assign fill_en   = ev_fill;
  assign fill_way  = vic_q;
  assign fill_tag  = tag_o;
  assign fill_line = mem_rline;

  assign wr_en   = req_we_q && (ev_hit || in_finish);
  assign wr_way  = in_finish ? vic_q : hit_way;
  assign wr_word = f_word(req_addr_q);
  assign wr_data = req_wd_q;

  assign repl_set   = set_o;
  assign repl_touch = ev_hit || ev_fill;
  assign repl_way   = ev_hit ? hit_way : vic_q;
endmodule

// File: rtl/wb_cache.sv
module wb_cache #(
  parameter int ADDR_W     = 32,
  parameter int SET_W      = 8,
  parameter int WAYS       = 4,
  parameter int LINE_WORDS = 4,
  parameter int WORD_W     = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cpu_valid,
  output logic                        cpu_ready,
  input  logic                        cpu_we,
  input  logic [ADDR_W-1:0]           cpu_addr,
  input  logic [WORD_W-1:0]           cpu_wdata,
  output logic                        cpu_resp,
  output logic [WORD_W-1:0]           cpu_rdata,
  output logic                        mem_req,
  output logic                        mem_we,
  output logic [ADDR_W-1:0]           mem_addr,
  output logic [LINE_WORDS*WORD_W-1:0] mem_wline,
  input  logic [LINE_WORDS*WORD_W-1:0] mem_rline,
  input  logic                        mem_ack,
  output logic [SET_W-1:0]            repl_set,
  input  logic [$clog2(WAYS)-1:0]     repl_victim,
  output logic                        repl_touch,
  output logic [$clog2(WAYS)-1:0]     repl_way
);
  localparam int BYTE_W = $clog2(WORD_W / 8);
  localparam int OFF_W  = $clog2(LINE_WORDS);
  localparam int TAG_W  = ADDR_W - SET_W - OFF_W - BYTE_W;
  localparam int WAY_W  = $clog2(WAYS);
  localparam int LINE_W = LINE_WORDS * WORD_W;

  logic [SET_W-1:0]            set_w;
  logic [TAG_W-1:0]            tag_w;
  logic [WAYS-1:0]             rd_valid, rd_dirty, hit_vec;
  logic [WAYS-1:0][TAG_W-1:0]  rd_tag;
  logic [WAYS-1:0][LINE_W-1:0] rd_line;
  logic                        hit;
  logic [WAY_W-1:0]            hit_way;
  logic                        fill_en, wr_en;
  logic [WAY_W-1:0]            fill_way, wr_way;
  logic [TAG_W-1:0]            fill_tag;
  logic [LINE_W-1:0]           fill_line;
  logic [OFF_W-1:0]            wr_word;
  logic [WORD_W-1:0]           wr_data;
  logic ev_hit, ev_miss_dirty, ev_miss_clean, ev_fill;

  wbc_arrays #(.SET_W(SET_W), .WAYS(WAYS), .WAY_W(WAY_W), .TAG_W(TAG_W),
               .WORD_W(WORD_W), .OFF_W(OFF_W), .LINE_W(LINE_W)) u_arrays (
    .clk(clk), .rst(rst), .set_i(set_w),
    .rd_valid(rd_valid), .rd_dirty(rd_dirty), .rd_tag(rd_tag), .rd_line(rd_line),
    .fill_en(fill_en), .fill_way(fill_way), .fill_tag(fill_tag), .fill_line(fill_line),
    .wr_en(wr_en), .wr_way(wr_way), .wr_word(wr_word), .wr_data(wr_data)
  );

  wbc_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_match (
    .way_valid(rd_valid), .way_tag(rd_tag), .req_tag(tag_w),
    .hit_vec(hit_vec), .hit(hit), .hit_way(hit_way)
  );

  wbc_ctrl #(.ADDR_W(ADDR_W), .SET_W(SET_W), .WAYS(WAYS), .WAY_W(WAY_W),
             .TAG_W(TAG_W), .WORD_W(WORD_W), .OFF_W(OFF_W), .BYTE_W(BYTE_W),
             .LINE_W(LINE_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_resp(cpu_resp), .cpu_rdata(cpu_rdata),
    .set_o(set_w), .tag_o(tag_w), .hit(hit), .hit_way(hit_way),
    .rd_valid(rd_valid), .rd_dirty(rd_dirty), .rd_tag(rd_tag), .rd_line(rd_line),
    .fill_en(fill_en), .fill_way(fill_way), .fill_tag(fill_tag), .fill_line(fill_line),
    .wr_en(wr_en), .wr_way(wr_way), .wr_word(wr_word), .wr_data(wr_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wline(mem_wline), .mem_rline(mem_rline), .mem_ack(mem_ack),
    .repl_set(repl_set), .repl_victim(repl_victim),
    .repl_touch(repl_touch), .repl_way(repl_way),
    .ev_hit(ev_hit), .ev_miss_dirty(ev_miss_dirty),
    .ev_miss_clean(ev_miss_clean), .ev_fill(ev_fill)
  );
endmodule

// File: rtl/wbc_checker.sv
module wbc_checker #(
  parameter int ADDR_W = 32,
  parameter int WAYS   = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_ready,
  input logic              cpu_resp,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              repl_touch,
  input logic [WAYS-1:0]   hit_vec,
  input logic              ev_hit,
  input logic              ev_miss_dirty,
  input logic              ev_miss_clean,
  input logic              ev_fill
);
  AST_RESP_PULSE: assert property (@(posedge clk) disable iff (rst)
    cpu_resp |=> !cpu_resp); // R1
  AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec)); // R3
  AST_HIT_NO_MEM: assert property (@(posedge clk) disable iff (rst)
    ev_hit |=> !mem_req); // R5
  AST_DIRTY_WB_FIRST: assert property (@(posedge clk) disable iff (rst)
    ev_miss_dirty |=> mem_req && mem_we); // R6
  AST_CLEAN_REFILL: assert property (@(posedge clk) disable iff (rst)
    ev_miss_clean |=> mem_req && !mem_we); // R7
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !cpu_ready); // R9
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R9
  AST_HIT_TOUCH: assert property (@(posedge clk) disable iff (rst)
    ev_hit |-> repl_touch); // R10
  AST_FILL_TOUCH: assert property (@(posedge clk) disable iff (rst)
    ev_fill |-> repl_touch); // R10
endmodule

bind wb_cache wbc_checker #(.ADDR_W(ADDR_W), .WAYS(WAYS)) u_chk (
  .clk(clk), .rst(rst), .cpu_ready(cpu_ready), .cpu_resp(cpu_resp),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .repl_touch(repl_touch), .hit_vec(hit_vec), .ev_hit(ev_hit),
  .ev_miss_dirty(ev_miss_dirty), .ev_miss_clean(ev_miss_clean), .ev_fill(ev_fill)
);

// File: tb/wb_cache_test.sv
module wb_cache_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic         cpu_valid = 1'b0, cpu_we = 1'b0;
  logic [31:0]  cpu_addr = '0, cpu_wdata = '0;
  logic         cpu_ready, cpu_resp;
  logic [31:0]  cpu_rdata;
  logic         mem_req, mem_we;
  logic [31:0]  mem_addr;
  logic [127:0] mem_wline;
  logic [127:0] mem_rline = '0;
  logic         mem_ack = 1'b0;
  logic [7:0]   repl_set;
  logic [1:0]   repl_victim = '0;
  logic         repl_touch;
  logic [1:0]   repl_way;

  wb_cache uut (
    .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
    .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_resp(cpu_resp), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wline(mem_wline), .mem_rline(mem_rline), .mem_ack(mem_ack),
    .repl_set(repl_set), .repl_victim(repl_victim),
    .repl_touch(repl_touch), .repl_way(repl_way)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // backing memory and shadow of the latest value of every word
  logic [31:0] bmem [logic [29:0]];
  logic [31:0] tru  [logic [29:0]];

  function automatic logic [31:0] init_word(input logic [29:0] wa);
    return ({2'b0, wa} * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction
  function automatic logic [31:0] mem_word(input logic [29:0] wa);
    return bmem.exists(wa) ? bmem[wa] : init_word(wa);
  endfunction
  function automatic logic [31:0] tru_word(input logic [29:0] wa);
    return tru.exists(wa) ? tru[wa] : init_word(wa);
  endfunction
  function automatic logic [127:0] tru_line(input logic [31:0] la);
    logic [127:0] l;
    for (int k = 0; k < 4; k++) l[k*32 +: 32] = tru_word({la[31:4], 2'(k)});
    return l;
  endfunction
  function automatic logic [31:0] mk(input int tag, input int set, input int w, input int b);
    return {20'(tag), 8'(set), 2'(w), 2'(b)};
  endfunction

  // memory responder: latency rotates 0..2 extra cycles
  int dly = 0, lat_cfg = 0;
  always @(negedge clk) begin
    if (rst) begin
      mem_ack = 1'b0; dly = 0;
    end else if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (mem_req) begin
      if (dly < lat_cfg) dly++;
      else begin
        dly = 0;
        lat_cfg = (lat_cfg + 1) % 3;
        if (mem_we) begin
          for (int k = 0; k < 4; k++) bmem[{mem_addr[31:4], 2'(k)}] = mem_wline[k*32 +: 32];
        end else begin
          for (int k = 0; k < 4; k++) mem_rline[k*32 +: 32] = mem_word({mem_addr[31:4], 2'(k)});
        end
        mem_ack = 1'b1;
      end
    end
  end

  // monitor of memory and replacement traffic
  int n_wb, n_fill, n_touch;
  bit order_bad;
  logic [31:0] wb_addr, fill_addr;
  logic [7:0]  t_set;
  logic [1:0]  t_way;
  always @(posedge clk) begin
    if (!rst) begin
      if (mem_req) chk(!cpu_ready, "R9 ready during miss", cpu_ready, 0);
      if (mem_req && mem_ack) begin
        if (mem_we) begin
          n_wb++; wb_addr = mem_addr;
          if (n_fill > 0) order_bad = 1;
          chk(mem_wline == tru_line(mem_addr), "R6 write-back line", mem_wline, tru_line(mem_addr));
        end else begin
          n_fill++; fill_addr = mem_addr;
        end
      end
      if (repl_touch) begin
        n_touch++; t_set = repl_set; t_way = repl_way;
      end
    end
  end

  // bench model of the tag state
  logic [19:0] mt [256][4];
  bit          mv [256][4];
  bit          md [256][4];
  logic [1:0]  rr [256];

  task automatic access(input logic [31:0] a, input bit we, input logic [31:0] wd,
                        input string rlabel);
    int s, w, lat, hw;
    bit hit, exp_wb;
    logic [19:0] t;
    logic [1:0] v;
    logic [31:0] exp_wb_addr, exp_rd;
    s = int'(a[11:4]); t = a[31:12]; w = int'(a[3:2]);
    hit = 0; hw = 0;
    for (int i = 0; i < 4; i++) if (mv[s][i] && mt[s][i] == t) begin hit = 1; hw = i; end
    v = rr[s];
    for (int i = 3; i >= 0; i--) if (!mv[s][i]) v = 2'(i);
    exp_wb = !hit && mv[s][v] && md[s][v];
    exp_wb_addr = {mt[s][v], 8'(s), 4'b0};
    if (hit) begin
      if (we) md[s][hw] = 1;
    end else begin
      if (mv[s][0] && mv[s][1] && mv[s][2] && mv[s][3]) rr[s] = rr[s] + 2'd1;
      mt[s][v] = t; mv[s][v] = 1; md[s][v] = we; hw = int'(v);
    end
    if (we) tru[a[31:2]] = wd;
    exp_rd = tru_word(a[31:2]);
    repl_victim = v;
    n_wb = 0; n_fill = 0; n_touch = 0; order_bad = 0;
    @(negedge clk);
    cpu_valid = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    @(negedge clk);
    cpu_valid = 0;
    lat = 1;
    while (!cpu_resp && lat < 200) begin @(negedge clk); lat++; end
    chk(cpu_resp == 1'b1, "R1 response seen", cpu_resp, 1);
    if (hit) chk(lat == 2, "R1 hit latency", lat, 2);
    if (!we) chk(cpu_rdata == exp_rd, rlabel, cpu_rdata, exp_rd);
    if (hit) chk(n_wb + n_fill == 0, we ? "R5 write hit mem traffic" : "R3 hit mem traffic",
                 n_wb + n_fill, 0);
    else begin
      chk(n_fill == 1, "R3 one refill per miss", n_fill, 1);
      chk(fill_addr == {t, 8'(s), 4'b0}, "R3 refill address", fill_addr, {t, 8'(s), 4'b0});
      chk(n_wb == int'(exp_wb), exp_wb ? "R6 dirty victim write-back" : "R7 clean victim no write-back",
          n_wb, exp_wb);
      if (exp_wb) chk(wb_addr == exp_wb_addr, "R6 write-back address", wb_addr, exp_wb_addr);
      chk(!order_bad, "R6 write-back before refill", order_bad, 0);
    end
    chk(n_touch == 1, "R10 touch count", n_touch, 1);
    chk(t_way == 2'(hw), "R10 touch way", t_way, hw);
    chk(t_set == 8'(s), "R10 touch set", t_set, s);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    int sets [4];
    sets = '{0, 1, 254, 255};
    for (int s = 0; s < 256; s++) begin
      rr[s] = 0;
      for (int i = 0; i < 4; i++) begin mv[s][i] = 0; md[s][i] = 0; mt[s][i] = '0; end
    end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(cpu_ready == 1'b1, "R2 ready after reset", cpu_ready, 1);
    chk(cpu_resp == 1'b0, "R2 resp after reset", cpu_resp, 0);
    chk(mem_req == 1'b0, "R2 mem idle after reset", mem_req, 0);

    // directed: set 3
    access(mk(1, 3, 0, 0), 0, 0, "R2 first read after reset");
    for (int w = 0; w < 4; w++) access(mk(1, 3, w, 0), 0, 0, "R4 word select");
    access(mk(1, 3, 1, 3), 0, 0, "R11 byte offset read");
    access(mk(1, 3, 2, 0), 1, 32'hDEADBEEF, "R5");
    access(mk(1, 3, 2, 0), 0, 0, "R5 write hit read back");
    access(mk(1, 3, 3, 2), 1, 32'h0BADF00D, "R11");
    access(mk(1, 3, 3, 0), 0, 0, "R11 byte offset write read back");
    for (int t = 2; t <= 5; t++) access(mk(t, 3, 0, 0), 0, 0, "R6 conflict fill read");
    access(mk(6, 3, 1, 1), 1, 32'hCAFE1234, "R8");
    access(mk(6, 3, 1, 0), 0, 0, "R8 write miss read back");
    for (int t = 7; t <= 10; t++) access(mk(t, 3, 2, 0), 0, 0, "R7 refill after clean fill");
    access(mk(6, 3, 1, 0), 0, 0, "R8 written word survives eviction");

    // near-exhaustive conflict sweep over edge sets
    for (int p = 0; p < 2; p++)
      for (int si = 0; si < 4; si++)
        for (int t = 0; t < 6; t++)
          for (int w = 0; w < 4; w++)
            access(mk(t + 16, sets[si], w, (t + w) % 4), (p == 0) && ((t + w) % 2 == 1),
                   32'h1000_0000 + 32'(p * 1000 + si * 100 + t * 4 + w), "R4 sweep read");

    // pseudo-random mix
    lf = 32'h1357_9BDF;
    for (int i = 0; i < 600; i++) begin
      lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
      access(mk(int'(lf[2:0]) + 40, sets[lf[4:3]], int'(lf[6:5]), int'(lf[8:7])),
             lf[9], lf, "R4 mixed read");
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule